// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a single-word-per-line, direct-mapped cache placed between a processor load/store port and a slower main-memory port. It keeps 1024 words of 32 bits (4 KB). Each line holds a valid flag, a tag and one data word. A 32-bit byte address picks the line from its middle bits and compares its upper bits against the stored tag.

A read that hits is accepted at once and answered on the next cycle. A read that misses holds the requester off. The block first waits until every queued store has reached memory. It then fetches the word, installs it, and serves the read as a hit.

Stores follow a write-through, no-write-allocate policy. A store refreshes the cached word only when its line already holds that address. Every store is also posted into a four-entry FIFO that drains to memory on its own. The processor stalls on a store only while that FIFO is full. The memory port carries one request at a time and holds it steady until memory acknowledges it.

Top module: `dmc_cache`

## Requirements
- R1: After reset no line is valid, cpu_rsp_valid and mem_req_valid are 0, and the first read to any address causes a memory read.
- R2: The line index is address bits [11:2] and the tag is bits [31:12]. Bits [1:0] are ignored for lookup, so a byte address inside a cached word hits. Two addresses with the same index but different tags evict each other.
- R3: A read that hits is accepted in the cycle it is presented (cpu_req_ready=1). cpu_rsp_valid and the word appear in the next cycle, with no memory access.
- R4: A read that misses keeps cpu_req_ready at 0 until the word has been fetched with a memory read at the word-aligned address and installed. The read is then answered with the fetched word, and a repeat read hits.
- R5: Every accepted store produces exactly one memory write. Its address is the store address with bits [1:0] cleared and its data is the stored word. Writes reach memory in acceptance order.
- R6: A store whose line holds a matching valid tag updates the cached word. A later read returns the new word without a memory read.
- R7: A store that misses does not install a line, so a later read of that address misses.
- R8: The store FIFO holds 4 entries. With memory not acknowledging, 4 stores are accepted without stall and the 5th waits with cpu_req_ready at 0 until an entry drains.
- R9: A read miss issues no memory read while any store is still queued. The fetched word therefore reflects every earlier store.
- R10: While mem_req_valid is 1 and mem_ack has not been seen, mem_req_write, mem_req_addr and mem_req_wdata stay unchanged.
- R11: cpu_rsp_valid is a one-cycle pulse that follows only an accepted read, never a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted at this edge |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned memory address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The hardest case to reach is a read miss that arrives while stores are still queued for memory. The fetch must wait behind them, and only the stored value may come back. The bench makes memory slow, posts several stores to lines the cache does not hold, and at once reads one of them back. It records how many writes memory had completed when the fetch was issued. A second hard case is a full store FIFO. The bench holds memory acknowledge off, fills all four entries, and releases memory from a parallel thread while the fifth store waits.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  // Controller phases: serve lookups, wait for queued stores, fetch a word.
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_FETCH  = 2'd2
  } ctl_state_e;

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int unsigned LINES  = 1024,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign count     = cnt_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       hit,
  input  logic       wb_empty,
  input  logic       wb_full,
  input  logic       mem_ack,
  output logic       req_ready,
  output logic       fetch_active,
  output logic       fill_en,
  output ctl_state_e state
);

  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOKUP: if (req_valid && !req_write && !hit) state_d = ST_DRAIN;
      ST_DRAIN:  if (wb_empty) state_d = ST_FETCH;
      ST_FETCH:  if (mem_ack) state_d = ST_LOOKUP;
      default:   state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_LOOKUP;
    else        state_q <= state_d;
  end

  always_comb begin
    req_ready = 1'b0;
    if (state_q == ST_LOOKUP) begin
      req_ready = req_write ? !wb_full : hit;
    end
  end

  assign fetch_active = (state_q == ST_FETCH);
  assign fill_en      = fetch_active && mem_ack;
  assign state        = state_q;

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LINES    = 1024,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned OFS_W   = $clog2(DATA_W / 8),
  localparam int unsigned IDX_W   = $clog2(LINES),
  localparam int unsigned TAG_W   = ADDR_W - IDX_W - OFS_W,
  localparam int unsigned CNT_W   = $clog2(WB_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  // Address arithmetic kept in functions so it reads as the specification.
  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_align(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] mask;
    mask = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};
    return a & mask;
  endfunction

  // Named internal events, observed by the bound checker.
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              lookup_hit;
  logic              rd_accept;
  logic              wr_accept;
  logic              fetch_active;
  logic              fill_en;
  logic              wb_empty;
  logic              wb_full;
  logic [CNT_W-1:0]  wb_count;
  logic              wb_pop;
  logic [ADDR_W-1:0] wb_head_addr;
  logic [DATA_W-1:0] wb_head_data;
  logic              store_wr_en;
  logic [DATA_W-1:0] store_wr_data;
  ctl_state_e        ctl_state;

  assign lookup_hit = line_valid && (line_tag == f_tag(cpu_req_addr));
  assign rd_accept  = cpu_req_valid && cpu_req_ready && !cpu_req_write;
  assign wr_accept  = cpu_req_valid && cpu_req_ready && cpu_req_write;

  dmc_line_store #(
    .LINES  (LINES),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (f_index(cpu_req_addr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (store_wr_en),
    .wr_idx   (f_index(cpu_req_addr)),
    .wr_tag   (f_tag(cpu_req_addr)),
    .wr_data  (store_wr_data)
  );

  // Fill on fetch return; update in place only on a store hit.
  assign store_wr_en   = fill_en || (wr_accept && lookup_hit);
  assign store_wr_data = fill_en ? mem_rdata : cpu_req_wdata;

  dmc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (cpu_req_valid),
    .req_write    (cpu_req_write),
    .hit          (lookup_hit),
    .wb_empty     (wb_empty),
    .wb_full      (wb_full),
    .mem_ack      (mem_ack),
    .req_ready    (cpu_req_ready),
    .fetch_active (fetch_active),
    .fill_en      (fill_en),
    .state        (ctl_state)
  );

  dmc_wbuf #(
    .DEPTH  (WB_DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_accept),
    .push_addr (f_align(cpu_req_addr)),
    .push_data (cpu_req_wdata),
    .pop       (wb_pop),
    .head_addr (wb_head_addr),
    .head_data (wb_head_data),
    .count     (wb_count),
    .empty     (wb_empty),
    .full      (wb_full)
  );

  // Memory port: a fetch only starts once the FIFO is empty, so the two never overlap.
  assign wb_pop        = mem_ack && !fetch_active && !wb_empty;
  assign mem_req_valid = fetch_active || !wb_empty;
  assign mem_req_write = !fetch_active;
  assign mem_req_addr  = fetch_active ? f_align(cpu_req_addr) : wb_head_addr;
  assign mem_req_wdata = wb_head_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= rd_accept;
      if (rd_accept) cpu_rsp_rdata <= line_data;
    end
  end

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned CNT_W   = $clog2(WB_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_write,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_ack,
  input logic              lookup_hit,
  input logic              rd_accept,
  input logic              wr_accept,
  input logic              wb_empty,
  input logic [CNT_W-1:0]  wb_count
);

  // R10: pending memory request holds until acknowledged.
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R9: a memory read only goes out with no store queued.
  a_r9_fetch_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> wb_empty);

  // R3: an accepted read is answered in the next cycle.
  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> cpu_rsp_valid);

  // R11: a response never appears without a read accepted the cycle before.
  a_r11_rsp_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(rd_accept));

  // R8: a store is taken only when the FIFO has room.
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> wb_count < CNT_W'(WB_DEPTH));

  // R4: a read that misses is held off.
  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && !cpu_req_write && !lookup_hit |-> !cpu_req_ready);

endmodule

bind dmc_cache dmc_cache_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WB_DEPTH (WB_DEPTH)
) u_dmc_cache_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_write (cpu_req_write),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_ack       (mem_ack),
  .lookup_hit    (lookup_hit),
  .rd_accept     (rd_accept),
  .wr_accept     (wr_accept),
  .wb_empty      (wb_empty),
  .wb_count      (wb_count)
);

// File: tb/test_dmc_cache.sv
module test_dmc_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dmc_cache i_dmc_cache (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem_q [logic [31:0]];
  int          mem_lat = 2;
  bit          mem_hold = 1'b0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          wr_at_last_rd = 0;
  logic [31:0] wlog_addr [64];
  logic [31:0] wlog_data [64];
  int          r10_bad = 0;

  function automatic logic [31:0] mem_default(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] mem_peek(input logic [31:0] a);
    if (mem_q.exists(a)) return mem_q[a];
    return mem_default(a);
  endfunction

  initial begin
    int          wait_cnt;
    bit          pend;
    logic [31:0] p_addr, p_data;
    logic        p_wr;
    wait_cnt = 0;
    pend = 1'b0;
    p_addr = '0; p_data = '0; p_wr = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req_valid) begin
        if (pend && (p_addr != mem_req_addr || p_wr != mem_req_write ||
                     (p_wr && p_data != mem_req_wdata)))
          r10_bad++;
        pend = 1'b1;
        p_addr = mem_req_addr; p_wr = mem_req_write; p_data = mem_req_wdata;
        if (!mem_hold) begin
          if (wait_cnt >= mem_lat) begin
            if (mem_req_write) begin
              mem_q[mem_req_addr] = mem_req_wdata;
              if (wr_cnt < 64) begin
                wlog_addr[wr_cnt] = mem_req_addr;
                wlog_data[wr_cnt] = mem_req_wdata;
              end
              wr_cnt++;
            end else begin
              mem_rdata = mem_peek(mem_req_addr);
              wr_at_last_rd = wr_cnt;
              rd_cnt++;
            end
            mem_ack = 1'b1;
            wait_cnt = 0;
            pend = 1'b0;
          end else begin
            wait_cnt++;
          end
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cpu_read(input logic [31:0] a, output logic [31:0] d,
                          output int stalls);
    stalls = 0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(posedge clk);
    @(negedge clk);
    check("R3", cpu_rsp_valid === 1'b1, 32'(cpu_rsp_valid), 32'd1, "rsp_valid after read");
    d = cpu_rsp_rdata;
    cpu_req_valid = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d,
                           output int stalls);
    stalls = 0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
    check("R11", cpu_rsp_valid === 1'b0, 32'(cpu_rsp_valid), 32'd0, "no rsp after store");
  endtask

  task automatic wait_writes(input int n);
    for (int i = 0; i < 400 && wr_cnt < n; i++) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    check("R1", cpu_rsp_valid === 1'b0, 32'(cpu_rsp_valid), 32'd0, "rsp_valid at reset");
    check("R1", mem_req_valid === 1'b0, 32'(mem_req_valid), 32'd0, "mem_req_valid at reset");
  endtask

  task automatic t_cold_and_hit();
    logic [31:0] d; int st; int r0;
    r0 = rd_cnt;
    cpu_read(32'h0000_0100, d, st);
    check("R1", rd_cnt == r0 + 1, 32'(rd_cnt), 32'(r0 + 1), "first read goes to memory");
    check("R4", d == mem_default(32'h100), d, mem_default(32'h100), "miss data");
    check("R4", st > 0, 32'(st), 32'd1, "miss stalls");
    cpu_read(32'h0000_0100, d, st);
    check("R3", st == 0 && rd_cnt == r0 + 1, 32'(st), 32'd0, "hit no stall, no mem read");
    check("R3", d == mem_default(32'h100), d, mem_default(32'h100), "hit data");
    cpu_read(32'h0000_0103, d, st);
    check("R2", st == 0 && d == mem_default(32'h100), d, mem_default(32'h100), "byte offset hits");
  endtask

  task automatic t_conflict();
    logic [31:0] d; int st; int r0;
    r0 = rd_cnt;
    cpu_read(32'h0000_1100, d, st);
    check("R2", rd_cnt == r0 + 1, 32'(rd_cnt), 32'(r0 + 1), "same index new tag misses");
    check("R4", d == mem_default(32'h1100), d, mem_default(32'h1100), "conflict data");
    cpu_read(32'h0000_0100, d, st);
    check("R2", rd_cnt == r0 + 2, 32'(rd_cnt), 32'(r0 + 2), "evicted line misses again");
  endtask

  task automatic t_write_hit();
    logic [31:0] d; int st; int r0; int w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_write(32'h0000_0102, 32'hCAFE_0001, st);
    wait_writes(w0 + 1);
    check("R5", wr_cnt == w0 + 1, 32'(wr_cnt), 32'(w0 + 1), "one memory write");
    check("R5", wlog_addr[w0] == 32'h100, wlog_addr[w0], 32'h100, "aligned write address");
    check("R5", wlog_data[w0] == 32'hCAFE_0001, wlog_data[w0], 32'hCAFE_0001, "write data");
    cpu_read(32'h0000_0100, d, st);
    check("R6", d == 32'hCAFE_0001 && rd_cnt == r0, d, 32'hCAFE_0001, "write hit updates cache");
  endtask

  task automatic t_write_miss();
    logic [31:0] d; int st; int r0; int w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_write(32'h0000_2200, 32'hBEEF_0002, st);
    wait_writes(w0 + 1);
    cpu_read(32'h0000_2200, d, st);
    check("R7", rd_cnt == r0 + 1, 32'(rd_cnt), 32'(r0 + 1), "write miss does not allocate");
    check("R7", d == 32'hBEEF_0002, d, 32'hBEEF_0002, "read returns stored word");
  endtask

  task automatic t_full();
    int st; int w0; int st5;
    w0 = wr_cnt;
    mem_hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cpu_write(32'h0000_4000 + 32'(i * 4), 32'h1000_0000 + 32'(i), st);
      check("R8", st == 0, 32'(st), 32'd0, "entries 1..4 accepted without stall");
    end
    st5 = 0;
    fork
      cpu_write(32'h0000_4010, 32'h1000_0004, st5);
      begin
        repeat (12) @(negedge clk);
        mem_hold = 1'b0;
      end
    join
    check("R8", st5 >= 10, 32'(st5), 32'd10, "fifth store waits for drain");
    wait_writes(w0 + 5);
    for (int i = 0; i < 5; i++) begin
      check("R5", wlog_addr[w0 + i] == 32'h4000 + 32'(i * 4) &&
                  wlog_data[w0 + i] == 32'h1000_0000 + 32'(i),
            wlog_data[w0 + i], 32'h1000_0000 + 32'(i), "FIFO drain order");
    end
  endtask

  task automatic t_read_behind_writes();
    logic [31:0] d; int st; int w0;
    w0 = wr_cnt;
    mem_lat = 6;
    cpu_write(32'h0000_8000, 32'hAAAA_0000, st);
    cpu_write(32'h0000_8004, 32'hAAAA_0001, st);
    cpu_write(32'h0000_8008, 32'hAAAA_0002, st);
    cpu_read(32'h0000_8004, d, st);
    check("R9", wr_at_last_rd == w0 + 3, 32'(wr_at_last_rd), 32'(w0 + 3), "fetch after all stores");
    check("R9", d == 32'hAAAA_0001, d, 32'hAAAA_0001, "read sees queued store");
    mem_lat = 2;
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_and_hit();
    t_conflict();
    t_write_hit();
    t_write_miss();
    t_full();
    t_read_behind_writes();
    check("R10", r10_bad == 0, 32'(r10_bad), 32'd0, "memory request held until ack");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule